// File: doc/BRIEF.md
# PCI Configuration Address/Data Responder

This unit gives a host CPU access to PCI configuration space through two registers. A write to the address port stores a configuration address. Each access to the data port decodes that stored address into bus, device, function and register offset. The unit then looks the tag up in a parameterized presence table and returns the selected function's configuration bytes. An absent function answers with the value that enumeration software expects. The block also supports the base-address sizing handshake and a big-endian CPU mode that swaps bytes on both ports.

Each table entry carries a valid bit, a bus/device/function tag and a 32-bit identity word. A function's configuration image is fixed at reset. Data-port writes other than a sizing write leave the image unchanged. Such a write raises a one-cycle strobe when its value differs from the stored one, which helps with debug. Read responses come back one clock after the request.

Top module: `cfg_access_responder`

## Requirements
- R1: A write to the address port (offset 0) stores a 32-bit configuration address, and a read of that port returns it. The address is decoded as bus = bits 23:16, device = bits 15:11, function = bits 10:8 and register offset = bits 7:0. The stored address resets to 0.
- R2: A data-port access (offset 4) selects the lowest-index table entry whose valid bit is set and whose tag equals the decoded bus/device/function. Entries whose valid bit is clear never match.
- R3: A data-port read with no matching entry returns 0xFFFFFFFF when the register offset is 0, and 0 otherwise.
- R4: Read data is assembled little-endian from the bytes at offsets reg to reg+len-1. The length len is reqSize+1, from 1 to 4 bytes, and unused upper bytes read as 0. The image holds the entry's identity word in bytes 0-3 and 0x00FFFFFF in bytes 4-7. Every other byte is 0.
- R5: An access whose last byte, reg+len-1, lies above 0xFF reads 0.
- R6: A data-port write whose lane-formatted value is 0xFFFFFFFF sets the sizing flag. This applies only when an entry matches and the register offset is from 0x10 to 0x24 inclusive. A write to an absent function, or to an offset outside that range, leaves the flag unchanged.
- R7: While the flag is set, a read at an offset from 0x10 to 0x24 uses the size image instead of the base image. In the size image, bytes 0x10-0x27 repeat the 32-bit mask 0x003FFFFF and all other bytes are 0. Every data-port read clears the flag.
- R8: Data-port writes never change the stored image. When an entry matches and the write is not a sizing write, wrMismatch pulses one cycle after the request if the written value differs from the assembled stored value.
- R9: In big-endian mode (cpuBigEndian=1), the address-port write value is fully byte-reversed before it is stored. The address-port read returns the stored value unchanged.
- R10: In big-endian mode, data-port write values and present-function read values are byte-reversed over the access length.
- R11: Reads of offsets other than 0 and 4 return 0, and writes to them have no effect.
- R12: rspValid is high exactly in the cycle after each read request, and rspData holds that read's value in the same cycle. A write never raises rspValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuBigEndian | input | 1 | Big-endian CPU byte order |
| reqValid | input | 1 | Register access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOffset | input | OFS_W | Register byte offset (0 address, 4 data) |
| reqSize | input | 2 | Access length minus one |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Read response valid |
| rspData | output | 32 | Read response data |
| wrMismatch | output | 1 | Non-sizing write differed from stored value |

## Verification
Some properties are checked on every cycle. A response appears only after a read, and the mismatch strobe only after a write. A sizing write always leaves the flag set, every data-port read clears it, and an absent function at a nonzero offset answers 0. Other behaviour can only be shown by the bench's scenarios, because it depends on the table and image contents. This covers the byte-lane assembly and its lengths, the lowest-index rule for duplicate tags, and the edges of the base-address range. It also covers the size mask that appears only after an arming write, and the effect of the big-endian swaps on both ports.

// File: rtl/cfg_access_pkg.sv
package cfg_access_pkg;

  localparam int REG_W = 8;
  localparam int TAG_W = 16;
  localparam int ENTRY_W = TAG_W + 1;
  localparam logic [REG_W-1:0] BAR_FIRST = 8'h10;
  localparam logic [REG_W-1:0] BAR_LAST = 8'h24;

  typedef struct packed {
    logic addrWr;
    logic addrRd;
    logic dataWr;
    logic dataRd;
    logic otherRd;
    logic sizeWr;
  } cfgStrobe_t;

  function automatic logic [31:0] swapOverLen(input logic [31:0] v, input logic [1:0] sz);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      if (i <= int'(sz)) r[8*i +: 8] = v[8*(int'(sz) - i) +: 8];
    end
    return r;
  endfunction

  function automatic logic [31:0] swapFull(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

endpackage

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl
  import cfg_access_pkg::*;
#(
  parameter int OFS_W = 4,
  parameter logic [OFS_W-1:0] ADDR_OFS = 4'h0,
  parameter logic [OFS_W-1:0] DATA_OFS = 4'h4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [OFS_W-1:0] reqOffset,
  input  logic             hit,
  input  logic             inBar,
  input  logic             wrAllOnes,
  output cfgStrobe_t       strobe,
  output logic             sizeFlag
);

  logic isAddr, isData;

  always_comb begin
    isAddr = (reqOffset == ADDR_OFS);
    isData = (reqOffset == DATA_OFS);
    strobe.addrWr  = reqValid && reqWrite && isAddr;
    strobe.addrRd  = reqValid && !reqWrite && isAddr;
    strobe.dataWr  = reqValid && reqWrite && isData;
    strobe.dataRd  = reqValid && !reqWrite && isData;
    strobe.otherRd = reqValid && !reqWrite && !isAddr && !isData;
    strobe.sizeWr  = strobe.dataWr && hit && inBar && wrAllOnes;
  end

  always_ff @(posedge clk) begin
    if (!rstN) sizeFlag <= 1'b0;
    else if (strobe.dataRd) sizeFlag <= 1'b0;
    else if (strobe.sizeWr) sizeFlag <= 1'b1;
  end

  // R6: an arming write always leaves the flag set
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sizeWr |=> sizeFlag);

  // R6: the flag only rises after a write request
  p_flag_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sizeFlag) |-> $past(reqValid && reqWrite));

  // R7: every data-port read drops the flag
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dataRd |=> !sizeFlag);

endmodule

// File: rtl/cfg_access_datapath.sv
module cfg_access_datapath
  import cfg_access_pkg::*;
#(
  parameter int NUM_FUNCS = 4,
  parameter logic [NUM_FUNCS*ENTRY_W-1:0] PRESENCE = '0,
  parameter logic [NUM_FUNCS*32-1:0] IDS = '0,
  parameter logic [31:0] CMD_INIT = 32'h00FF_FFFF,
  parameter logic [31:0] SIZE_MASK = 32'h003F_FFFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuBigEndian,
  input  logic [1:0]  reqSize,
  input  logic [31:0] reqWdata,
  input  cfgStrobe_t  strobe,
  input  logic        sizeFlag,
  output logic        hit,
  output logic        inBar,
  output logic        wrAllOnes,
  output logic        rspValid,
  output logic [31:0] rspData,
  output logic        wrMismatch
);

  localparam logic [REG_W-1:0] SIZE_LAST = BAR_LAST + 8'd3;

  logic [31:0]          cfgAddr;
  logic [REG_W-1:0]     regOfs;
  logic [NUM_FUNCS-1:0] matchVec;
  logic [31:0]          hitId;
  logic [REG_W:0]       lastByte;
  logic                 fits, useSize;
  logic [31:0]          assembled, cfgWord, wrValue, readValue;

  function automatic logic [7:0] imageByte(input logic [31:0] id, input logic [REG_W-1:0] a,
                                           input logic sel);
    if (sel) begin
      if (a >= BAR_FIRST && a <= SIZE_LAST) return SIZE_MASK[{a[1:0], 3'b000} +: 8];
      return 8'h00;
    end
    if (a[REG_W-1:2] == '0) return id[{a[1:0], 3'b000} +: 8];
    if (a[REG_W-1:2] == 6'd1) return CMD_INIT[{a[1:0], 3'b000} +: 8];
    return 8'h00;
  endfunction

  assign regOfs = cfgAddr[REG_W-1:0];

  for (genvar i = 0; i < NUM_FUNCS; i++) begin : g_match
    assign matchVec[i] = PRESENCE[i*ENTRY_W + TAG_W] &&
                         (PRESENCE[i*ENTRY_W +: TAG_W] == cfgAddr[23:8]);
  end

  // lowest index wins: scan from the top, later hits overwrite
  always_comb begin
    hit = 1'b0;
    hitId = '0;
    for (int i = NUM_FUNCS - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        hit = 1'b1;
        hitId = IDS[32*i +: 32];
      end
    end
  end

  always_comb begin
    lastByte  = {1'b0, regOfs} + {{(REG_W-1){1'b0}}, reqSize};
    fits      = !lastByte[REG_W];
    inBar     = (regOfs >= BAR_FIRST) && (regOfs <= BAR_LAST);
    useSize   = sizeFlag && inBar;
    assembled = '0;
    for (int i = 0; i < 4; i++) begin
      if (i <= int'(reqSize))
        assembled[8*i +: 8] = imageByte(hitId, regOfs + REG_W'(i), useSize);
    end
    cfgWord   = fits ? assembled : 32'h0;
    wrValue   = cpuBigEndian ? swapOverLen(reqWdata, reqSize) : reqWdata;
    wrAllOnes = (wrValue == 32'hFFFF_FFFF);
    if (!hit) readValue = (regOfs == '0) ? 32'hFFFF_FFFF : 32'h0;
    else      readValue = cpuBigEndian ? swapOverLen(cfgWord, reqSize) : cfgWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgAddr    <= '0;
      rspValid   <= 1'b0;
      rspData    <= '0;
      wrMismatch <= 1'b0;
    end else begin
      if (strobe.addrWr) cfgAddr <= cpuBigEndian ? swapFull(reqWdata) : reqWdata;
      rspValid   <= strobe.addrRd || strobe.dataRd || strobe.otherRd;
      if (strobe.addrRd)       rspData <= cfgAddr;
      else if (strobe.dataRd)  rspData <= readValue;
      else if (strobe.otherRd) rspData <= '0;
      wrMismatch <= strobe.dataWr && hit && !strobe.sizeWr && (wrValue != cfgWord);
    end
  end

  // R3: absent function at a nonzero offset answers zero
  p_absent_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataRd && !hit && regOfs != '0) |=> (rspData == 32'h0));

  // R8: the strobe only follows a data-port write
  p_mismatch_after_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrMismatch |-> $past(strobe.dataWr));

  // R1: the stored address only moves on an address-port write
  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.addrWr) |-> $stable(cfgAddr));

endmodule

// File: rtl/cfg_access_responder.sv
module cfg_access_responder
  import cfg_access_pkg::*;
#(
  parameter int NUM_FUNCS = 4,
  parameter int OFS_W = 4,
  parameter logic [OFS_W-1:0] ADDR_OFS = 4'h0,
  parameter logic [OFS_W-1:0] DATA_OFS = 4'h4,
  parameter logic [NUM_FUNCS*ENTRY_W-1:0] PRESENCE = {
    {1'b1, 8'h00, 5'd2, 3'd1},
    {1'b1, 8'h00, 5'd2, 3'd1},
    {1'b1, 8'h00, 5'd1, 3'd0},
    {1'b0, 8'h00, 5'd3, 3'd0}},
  parameter logic [NUM_FUNCS*32-1:0] IDS = {
    32'hCCCC_9ABC, 32'hBBBB_5678, 32'hAAAA_1234, 32'h1111_0000},
  parameter logic [31:0] CMD_INIT = 32'h00FF_FFFF,
  parameter logic [31:0] SIZE_MASK = 32'h003F_FFFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuBigEndian,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [OFS_W-1:0] reqOffset,
  input  logic [1:0]       reqSize,
  input  logic [31:0]      reqWdata,
  output logic             rspValid,
  output logic [31:0]      rspData,
  output logic             wrMismatch
);

  cfgStrobe_t strobe;
  logic sizeFlag, hit, inBar, wrAllOnes;

  cfg_access_ctrl #(.OFS_W(OFS_W), .ADDR_OFS(ADDR_OFS), .DATA_OFS(DATA_OFS)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .hit(hit), .inBar(inBar), .wrAllOnes(wrAllOnes),
    .strobe(strobe), .sizeFlag(sizeFlag));

  cfg_access_datapath #(.NUM_FUNCS(NUM_FUNCS), .PRESENCE(PRESENCE), .IDS(IDS),
                        .CMD_INIT(CMD_INIT), .SIZE_MASK(SIZE_MASK)) dp_i (
    .clk(clk), .rstN(rstN), .cpuBigEndian(cpuBigEndian), .reqSize(reqSize),
    .reqWdata(reqWdata), .strobe(strobe), .sizeFlag(sizeFlag), .hit(hit),
    .inBar(inBar), .wrAllOnes(wrAllOnes), .rspValid(rspValid), .rspData(rspData),
    .wrMismatch(wrMismatch));

  // R12: a response appears only one cycle after a read request
  p_rsp_after_read_r12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && !reqWrite));

  // R12: every read request is answered
  p_read_answered_r12: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> rspValid);

endmodule

// File: tb/cfg_access_responder_tb.sv
module cfg_access_responder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_PORT = 4'h0;
  localparam logic [3:0] D_PORT = 4'h4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuBigEndian = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [3:0] reqOffset = '0;
  logic [1:0] reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic rspValid, wrMismatch;
  logic [31:0] rspData;

  int total = 0;
  int bad = 0;
  logic seenValid, seenMis;
  logic [31:0] seenData;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_access_responder dut_i (
    .clk(clk), .rstN(rstN), .cpuBigEndian(cpuBigEndian), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqOffset(reqOffset), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .wrMismatch(wrMismatch));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [3:0] ofs, input logic [1:0] sz,
                        input logic [31:0] wd);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqOffset = ofs; reqSize = sz; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    seenValid = rspValid; seenData = rspData; seenMis = wrMismatch;
  endtask

  task automatic setAddr(input logic [31:0] a);
    access(1'b1, A_PORT, 2'd3, a);
  endtask

  task automatic readData(input logic [1:0] sz, input logic [31:0] exp, input string req);
    access(1'b0, D_PORT, sz, 32'h0);
    check(req, {31'b0, seenValid}, 32'h1);
    check(req, seenData, exp);
  endtask

  task automatic testReset();
    check("R12 reset rspValid", {31'b0, rspValid}, 32'h0);
    check("R8 reset wrMismatch", {31'b0, wrMismatch}, 32'h0);
    access(1'b0, A_PORT, 2'd3, 32'h0);
    check("R1 reset address", seenData, 32'h0);
  endtask

  task automatic testAddrPort();
    setAddr(32'h0000_0804);
    check("R12 write gives no response", {31'b0, seenValid}, 32'h0);
    access(1'b0, A_PORT, 2'd3, 32'h0);
    check("R1 address readback", seenData, 32'h0000_0804);
  endtask

  task automatic testAssembly();
    setAddr(32'h0000_0800); readData(2'd3, 32'hAAAA_1234, "R4 id word");
    setAddr(32'h0000_0804); readData(2'd3, 32'h00FF_FFFF, "R4 command word");
    setAddr(32'h0000_0801); readData(2'd0, 32'h0000_0012, "R4 one byte");
    setAddr(32'h0000_0802); readData(2'd1, 32'h0000_AAAA, "R4 two bytes");
    setAddr(32'h0000_0805); readData(2'd2, 32'h0000_FFFF, "R4 three bytes");
    setAddr(32'h0000_0810); readData(2'd3, 32'h0, "R4 base reads zero");
  endtask

  task automatic testPriority();
    setAddr(32'h0000_1100); readData(2'd3, 32'hBBBB_5678, "R2 lowest index wins");
  endtask

  task automatic testAbsent();
    setAddr(32'h0000_1800); readData(2'd3, 32'hFFFF_FFFF, "R3 invalid entry reg0");
    setAddr(32'h0000_1804); readData(2'd3, 32'h0, "R3 invalid entry reg4");
    setAddr(32'h0001_0800); readData(2'd3, 32'hFFFF_FFFF, "R2 bus mismatch absent");
  endtask

  task automatic testOutOfRange();
    setAddr(32'h0000_08FE); readData(2'd3, 32'h0, "R5 beyond space");
    setAddr(32'h0000_08FD); readData(2'd2, 32'h0, "R5 last byte inside");
  endtask

  task automatic testSizing();
    setAddr(32'h0000_0810);
    access(1'b1, D_PORT, 2'd3, 32'hFFFF_FFFF);
    check("R8 sizing write no strobe", {31'b0, seenMis}, 32'h0);
    readData(2'd3, 32'h003F_FFFF, "R7 size mask at 0x10");
    readData(2'd3, 32'h0, "R7 flag cleared by read");
    setAddr(32'h0000_0824);
    access(1'b1, D_PORT, 2'd3, 32'hFFFF_FFFF);
    readData(2'd3, 32'h003F_FFFF, "R6 upper edge 0x24");
    setAddr(32'h0000_0828);
    access(1'b1, D_PORT, 2'd3, 32'hFFFF_FFFF);
    check("R8 out of range all-ones strobes", {31'b0, seenMis}, 32'h1);
    readData(2'd3, 32'h0, "R6 0x28 not armed");
    setAddr(32'h0000_080C);
    access(1'b1, D_PORT, 2'd3, 32'hFFFF_FFFF);
    setAddr(32'h0000_0810);
    readData(2'd3, 32'h0, "R6 0x0C write does not arm");
    access(1'b1, D_PORT, 2'd3, 32'hFFFF_FFFF);
    setAddr(32'h0000_0800);
    readData(2'd3, 32'hAAAA_1234, "R7 flag ignored outside range");
    setAddr(32'h0000_0810);
    readData(2'd3, 32'h0, "R7 cleared by outside read");
    setAddr(32'h0000_1810);
    access(1'b1, D_PORT, 2'd3, 32'hFFFF_FFFF);
    setAddr(32'h0000_0810);
    readData(2'd3, 32'h0, "R6 absent write does not arm");
  endtask

  task automatic testWrites();
    setAddr(32'h0000_0804);
    access(1'b1, D_PORT, 2'd3, 32'h00FF_FFFF);
    check("R8 equal write no strobe", {31'b0, seenMis}, 32'h0);
    access(1'b1, D_PORT, 2'd3, 32'h1234_5678);
    check("R8 differing write strobes", {31'b0, seenMis}, 32'h1);
    readData(2'd3, 32'h00FF_FFFF, "R8 write leaves image");
    setAddr(32'h0000_1804);
    access(1'b1, D_PORT, 2'd3, 32'h1234_5678);
    check("R8 absent write no strobe", {31'b0, seenMis}, 32'h0);
  endtask

  task automatic testOther();
    setAddr(32'h0000_0800);
    access(1'b1, 4'h8, 2'd3, 32'hDEAD_BEEF);
    access(1'b0, 4'h8, 2'd3, 32'h0);
    check("R11 other offset reads zero", seenData, 32'h0);
    check("R11 other read responds", {31'b0, seenValid}, 32'h1);
    access(1'b0, A_PORT, 2'd3, 32'h0);
    check("R11 other write ignored", seenData, 32'h0000_0800);
  endtask

  task automatic testBigEndian();
    cpuBigEndian = 1'b1;
    setAddr(32'h0408_0000);
    access(1'b0, A_PORT, 2'd3, 32'h0);
    check("R9 address reversed", seenData, 32'h0000_0804);
    readData(2'd3, 32'hFFFF_FF00, "R10 word reversed");
    setAddr(32'h0008_0000);
    readData(2'd1, 32'h0000_3412, "R10 two-byte reversed");
    setAddr(32'h1008_0000);
    access(1'b1, D_PORT, 2'd3, 32'hFFFF_FFFF);
    readData(2'd3, 32'hFFFF_3F00, "R10 size mask reversed");
    setAddr(32'h0408_0000);
    access(1'b1, D_PORT, 2'd3, 32'hFFFF_FF00);
    check("R10 write reversed matches", {31'b0, seenMis}, 32'h0);
    cpuBigEndian = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testAddrPort();
    testAssembly();
    testPriority();
    testAbsent();
    testOutOfRange();
    testSizing();
    testWrites();
    testOther();
    testBigEndian();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule